// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is a two-wire serial bus slave that fronts a 512-byte memory built from registers. A bus master opens a transfer with a START, sends an address byte whose upper nibble identifies the block and whose bit 1 supplies the ninth memory address bit, and then either writes bytes into a 16-byte page or reads bytes back in sequence. SCL and SDA reach the block as raw pins. Each is passed through a two-flop synchronizer on the faster system clock before any edge is detected. The block returns SDA as an open-drain pull-down enable.

Written bytes collect in a page buffer and are applied to the array only when the STOP that closes the write arrives. A timed internal write cycle starts at that point. For its whole length the slave leaves the bus alone. A read that comes with no word address continues from an internal address counter. A master gets a random read by sending a dummy write of the word address, then a repeated START and a read.

Both bus pins carry fixed protocol traffic and the slave has no way to stall the master, so the block has no valid/ready edge. Flow control is limited to the acknowledge bit, plus the slave's silence while a write cycle runs.

Top module: `i2c_mem_slave`

## Requirements
- R1: START is an SDA fall while SCL is high and STOP is an SDA rise while SCL is high. Outside the write cycle, a START at any point abandons the current transfer and begins address decoding. No byte is acknowledged unless a START came first.
- R2: The address byte is acknowledged on the ninth clock only if its bits [7:4] equal 4'b1010. Bits [3:2] are ignored, bit 1 is memory address bit 8 and bit 0 selects read (1) or write (0). On a mismatch the slave gives no acknowledge and ignores the bus until the next START or STOP.
- R3: In a write, the byte after the address byte is the word address. It gives address bits [7:0], and bit 8 comes from the address byte. The slave acknowledges the word address and every data byte. A single data byte followed by STOP writes that one location.
- R4: Each data byte in a write advances only address bits [3:0], which wrap from 15 to 0. Bits [8:4] stay fixed, so bytes after the 16th overwrite earlier locations in the same page.
- R5: Buffered bytes reach the array only at the STOP that ends the write. If a START arrives instead, the buffered bytes are discarded and the array is unchanged.
- R6: A STOP that commits data starts a write cycle of WR_CYCLES system clocks. During that cycle SDA is never pulled low and START, STOP and address bytes are ignored. Afterwards the slave responds normally.
- R7: A read sends each byte MSB first, starting from the address counter, and then releases SDA. If the master acknowledges, the next byte follows. If it does not, SDA stays released until the next START or STOP.
- R8: The address counter points one past the last byte written or sent. In reads it increments across all 9 bits and wraps from 511 to 0. A discarded write still leaves the counter advanced.
- R9: A write of only the word address, followed by a repeated START and a read, returns data from that word address.
- R10: After reset every memory byte is 0, the address counter is 0 and SDA is released.
- R11: The SDA pull-down enable changes only while the synchronized SCL is low, so bits sent by the slave are stable for the whole SCL high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock pin level |
| sda_i | input | 1 | Raw serial data pin level (the resolved bus) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with its default 9-bit address and 16-byte pages and shortens WR_CYCLES to 150. That is long enough that an address byte sent right after a committing STOP lands fully inside the write cycle. It is also short enough that all 32 pages can be written with busy polling after each one. After the array is filled it is read back in a single 513-byte sequential read. That run covers every location, the crossing of the address-bit-8 boundary and the 511-to-0 wrap. Further sequences cover in-page wrap past 16 bytes, single-byte writes, discarded writes and released SDA after a not-acknowledge. Every expected byte comes from an arithmetic fill pattern and a model array that the bench keeps in step.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP,
    ST_BUSY
  } bus_state_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  // one extra stage keeps the previous synchronized level for edge detection
  logic [SYNC_STAGES:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_lvl  = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl  = sda_pipe[SYNC_STAGES-1];
  assign scl_prev = scl_pipe[SYNC_STAGES];
  assign sda_prev = sda_pipe[SYNC_STAGES];

  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_data,
  input  logic                     buf_clear,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] page_sel,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      bufd [PAGE];
  logic [PAGE-1:0] bufv;

  // page staging buffer: one byte slot and one valid flag per in-page offset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufv <= '0;
      for (int i = 0; i < PAGE; i++) bufd[i] <= '0;
    end else if (buf_clear) begin
      bufv <= '0;
    end else if (buf_we) begin
      bufd[buf_idx] <= buf_data;
      bufv[buf_idx] <= 1'b1;
    end
  end

  // all staged bytes land in one cycle when the write cycle begins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (bufv[i]) mem[{page_sel, PAGE_W'(i)}] <= bufd[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];

  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |=> (bufv == '0));

  p_stage_marks_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && !buf_clear) |=> bufv[$past(buf_idx)]);

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter int         ADDR_W    = 9,
  parameter int         PAGE_W    = 4,
  parameter logic [3:0] DEV_ID    = 4'b1010,
  parameter int         WR_CYCLES = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_lvl,
  input  logic                     sda_lvl,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_ev,
  input  logic                     stop_ev,
  input  logic [7:0]               rd_data,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     buf_we,
  output logic [PAGE_W-1:0]        buf_idx,
  output logic [7:0]               buf_data,
  output logic                     buf_clear,
  output logic                     commit,
  output logic [ADDR_W-PAGE_W-1:0] page_sel,
  output logic                     sda_oe
);
  localparam int HI_W = ADDR_W - 8;
  localparam int BCW  = $clog2(WR_CYCLES + 1);

  bus_state_t        state_q, nxt_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HI_W-1:0]   a_hi_q;
  logic              oe_q, pend_q, mack_q;
  logic [BCW-1:0]    busy_q;

  logic live, byte_done;
  assign live      = (state_q != ST_BUSY);
  assign byte_done = scl_fall && (cnt_q == 4'd8);

  assign buf_we    = live && !start_ev && !stop_ev && (state_q == ST_WDATA) && byte_done;
  assign buf_idx   = addr_q[PAGE_W-1:0];
  assign buf_data  = sh_q;
  assign commit    = live && stop_ev && pend_q;
  assign buf_clear = commit || (live && start_ev);
  assign page_sel  = addr_q[ADDR_W-1:PAGE_W];
  assign rd_addr   = addr_q;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nxt_q   <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      a_hi_q  <= '0;
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
      mack_q  <= 1'b0;
      busy_q  <= '0;
    end else if (!live) begin
      // write cycle: the bus is ignored until the timer expires
      if (busy_q == BCW'(WR_CYCLES - 1)) begin
        busy_q  <= '0;
        state_q <= ST_IDLE;
      end else begin
        busy_q <= busy_q + 1'b1;
      end
    end else if (start_ev) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else if (stop_ev) begin
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
      busy_q  <= '0;
      state_q <= pend_q ? ST_BUSY : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_lvl};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            cnt_q <= '0;
            if (state_q == ST_DEV) begin
              if (sh_q[7:4] == DEV_ID) begin
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
                nxt_q   <= sh_q[0] ? ST_RDATA : ST_WADDR;
                a_hi_q  <= sh_q[HI_W:1];
              end else begin
                state_q <= ST_SKIP;
              end
            end else if (state_q == ST_WADDR) begin
              addr_q  <= {a_hi_q, sh_q};
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
              nxt_q   <= ST_WDATA;
            end else begin
              addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
              pend_q  <= 1'b1;
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
              nxt_q   <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (nxt_q == ST_RDATA) begin
              sh_q    <= rd_data;
              oe_q    <= ~rd_data[7];
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= nxt_q;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              sh_q <= {sh_q[6:0], 1'b0};
              oe_q <= ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_lvl;
          end else if (scl_fall) begin
            cnt_q <= '0;
            if (mack_q) begin
              sh_q    <= rd_data;
              oe_q    <= ~rd_data[7];
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_start_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && state_q != ST_BUSY) |=> (state_q == ST_DEV));

  p_page_bits_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W])));

  p_commit_enters_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (state_q == ST_BUSY));

  p_quiet_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |-> !sda_oe);

  p_busy_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |-> (busy_q < BCW'(WR_CYCLES)));

  p_sda_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_lvl);

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int         ADDR_W    = 9,
  parameter int         PAGE_W    = 4,
  parameter logic [3:0] DEV_ID    = 4'b1010,
  parameter int         WR_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int PG_W = ADDR_W - PAGE_W;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0]        rd_data, buf_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [PAGE_W-1:0] buf_idx;
  logic [PG_W-1:0]   page_sel;
  logic              buf_we, buf_clear, commit;

  i2c_bus_sync #(.SYNC_STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_mem_ctrl #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .DEV_ID    (DEV_ID),
    .WR_CYCLES (WR_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .buf_data  (buf_data),
    .buf_clear (buf_clear),
    .commit    (commit),
    .page_sel  (page_sel),
    .sda_oe    (sda_oe)
  );

  i2c_mem_array #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .buf_data  (buf_data),
    .buf_clear (buf_clear),
    .commit    (commit),
    .page_sel  (page_sel),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

endmodule

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
  localparam int WRC = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  int hi_glitch = 0;
  bit done = 1'b0;
  logic [7:0] model [512];

  always #2.5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_mem_slave #(.WR_CYCLES(WRC)) i_i2c_mem_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe)
  );

  function automatic logic [7:0] fill(input int a);
    return 8'((a * 37 + 11) ^ (a >> 4));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    logic r1;
    wait_n(2);
    m_sda = b;
    wait_n(5);
    scl = 1'b1;
    wait_n(1);
    r1 = sda_bus;
    wait_n(3);
    r = sda_bus;
    if (r1 !== r) hi_glitch++;
    wait_n(1);
    scl = 1'b0;
  endtask

  task automatic do_start();
    wait_n(2);
    m_sda = 1'b1;
    wait_n(4);
    scl = 1'b1;
    wait_n(5);
    m_sda = 1'b0;
    wait_n(5);
    scl = 1'b0;
  endtask

  task automatic do_stop();
    wait_n(2);
    m_sda = 1'b0;
    wait_n(4);
    scl = 1'b1;
    wait_n(5);
    m_sda = 1'b1;
    wait_n(5);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      d[i] = r;
    end
    bit_io(!give_ack, r);
  endtask

  // dummy write of the word address, then repeated START and read address byte (R9)
  task automatic open_read_at(input int a, input string req);
    bit ack;
    do_start();
    send_byte(8'hA0 | 8'((a >> 8) << 1), ack);
    chk(ack, req, "dev byte ack", ack, 1);
    send_byte(8'(a), ack);
    chk(ack, req, "word addr ack", ack, 1);
    do_start();
    send_byte(8'hA1, ack);
    chk(ack, req, "read dev ack", ack, 1);
  endtask

  initial begin
    wait_n(195000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic r;
    logic [7:0] d;
    for (int i = 0; i < 512; i++) model[i] = 8'h00;

    wait_n(10);
    chk(sda_oe === 1'b0, "R10", "sda released in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    wait_n(10);
    chk(sda_oe === 1'b0, "R10", "sda released after reset", int'(sda_oe), 0);

    // R1: address byte without START is not acknowledged
    wait_n(2);
    scl = 1'b0;
    send_byte(8'hA0, ack);
    chk(!ack, "R1", "ack without START", ack, 0);
    do_stop();

    // R10 / R8: current address read after reset returns location 0 = 0
    do_start();
    send_byte(8'hA1, ack);
    chk(ack, "R2", "matching read address ack", ack, 1);
    recv_byte(1'b0, d);
    chk(d == 8'h00, "R10", "byte at counter 0", d, 0);
    do_stop();

    // R2: mismatching id, then the bus stays ignored until STOP
    do_start();
    send_byte(8'hB0, ack);
    chk(!ack, "R2", "wrong id nack", ack, 0);
    send_byte(8'hA0, ack);
    chk(!ack, "R2", "ignored after mismatch", ack, 0);
    do_stop();

    // R3/R4/R5/R6: fill all 32 pages, poll the write cycle after each
    for (int p = 0; p < 32; p++) begin
      do_start();
      send_byte(8'hA0 | 8'((p >> 4) << 1), ack);
      chk(ack, "R3", "page dev ack", ack, 1);
      send_byte(8'(p * 16), ack);
      chk(ack, "R3", "page word addr ack", ack, 1);
      for (int k = 0; k < 16; k++) begin
        send_byte(fill(p * 16 + k), ack);
        chk(ack, "R3", "page data ack", ack, 1);
        model[p * 16 + k] = fill(p * 16 + k);
      end
      do_stop();
      do_start();
      send_byte(8'hA0, ack);
      chk(!ack, "R6", "nack during write cycle", ack, 0);
      do_stop();
      do_start();
      send_byte(8'hA0, ack);
      chk(ack, "R6", "ack after write cycle", ack, 1);
      do_stop();
    end

    // R7/R8/R9: sequential read of the whole array plus one wrapped byte
    open_read_at(0, "R9");
    for (int i = 0; i < 513; i++) begin
      recv_byte(i != 512, d);
      chk(d == model[i % 512], (i == 512) ? "R8" : "R7", "sequential byte", d, model[i % 512]);
    end
    do_stop();

    // R4: 18 bytes starting at 0x13E wrap inside page 0x130
    do_start();
    send_byte(8'hA2, ack);
    chk(ack, "R4", "wrap dev ack", ack, 1);
    send_byte(8'h3E, ack);
    chk(ack, "R4", "wrap word addr ack", ack, 1);
    for (int k = 0; k < 18; k++) begin
      send_byte(8'(8'hC0 + k), ack);
      chk(ack, "R4", "wrap data ack", ack, 1);
      model[9'h130 + ((14 + k) % 16)] = 8'(8'hC0 + k);
    end
    do_stop();
    wait_n(2 * WRC);
    open_read_at(9'h12F, "R4");
    for (int i = 0; i < 18; i++) begin
      recv_byte(i != 17, d);
      chk(d == model[9'h12F + i], "R4", "page wrap contents", d, model[9'h12F + i]);
    end
    do_stop();

    // R3/R8: single byte write, then current address read is one past it
    do_start();
    send_byte(8'hA2, ack);
    chk(ack, "R3", "byte write dev ack", ack, 1);
    send_byte(8'h05, ack);
    chk(ack, "R3", "byte write addr ack", ack, 1);
    send_byte(8'h5A, ack);
    chk(ack, "R3", "byte write data ack", ack, 1);
    model[9'h105] = 8'h5A;
    do_stop();
    wait_n(2 * WRC);
    do_start();
    send_byte(8'hA1, ack);
    chk(ack, "R8", "current read ack", ack, 1);
    recv_byte(1'b0, d);
    chk(d == model[9'h106], "R8", "current read after write", d, model[9'h106]);
    do_stop();
    open_read_at(9'h105, "R3");
    recv_byte(1'b0, d);
    chk(d == 8'h5A, "R3", "single byte written", d, 8'h5A);
    do_stop();

    // R5: data followed by repeated START is discarded, counter still advanced
    do_start();
    send_byte(8'hA0, ack);
    send_byte(8'h20, ack);
    send_byte(8'h77, ack);
    chk(ack, "R5", "data ack before abort", ack, 1);
    do_start();
    send_byte(8'hA1, ack);
    chk(ack, "R1", "restart decodes address", ack, 1);
    recv_byte(1'b0, d);
    chk(d == model[9'h021], "R8", "counter past discarded byte", d, model[9'h021]);
    do_stop();
    open_read_at(9'h020, "R5");
    recv_byte(1'b0, d);
    chk(d == model[9'h020], "R5", "discarded byte not written", d, model[9'h020]);

    // R7: after the master's NACK the slave keeps SDA released
    for (int i = 0; i < 9; i++) begin
      bit_io(1'b1, r);
      chk(r === 1'b1, "R7", "sda released after nack", int'(r), 1);
    end
    do_stop();

    chk(hi_glitch == 0, "R11", "sda changes while scl high", hi_glitch, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule